// File: doc/BRIEF.md
# Daughterboard GPIO Bank with Radio-State Output Muxing

This block runs a bank of general-purpose pins split into a receive-side group (the low half) and a transmit-side group (the high half). Each pin has a direction bit. Each pin also has a two-bit source code that decides what drives the pin while it is an output. The choices are a software-written value, a word chosen automatically from the radio's current activity, or a bit from one of two debug buses. Pins set as inputs are released, and their pad levels come back through a synchronizer as a readable word.

A write-only settings bus programs every register, one address per register. The automatic (ATR) output comes from eight stored words, one per side for each of the four radio states. Two status inputs, `tx_active` and `rx_active`, pick the current state. The surrounding pad ring is expected to turn `pad_oe` and `pad_out` into a real tristate driver.

Top module: `gpio_atr_bank`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all zero), `pad_out` is all zero and `pad_rd` is zero.
- R2: A write to offset 1 (direction) sets `pad_oe` bit for bit: bit p equal to 1 makes pin p an output.
- R3: A pin whose direction bit is 0 drives 0 on its `pad_out` bit, whatever its source code.
- R4: Source code 0 drives an output pin from the matching bit of the software value register at offset 0.
- R5: Source code 1 drives an output pin from the ATR word for the current state, where {rx_active,tx_active} = 00 is idle (state 0), 01 is transmit only (state 1), 10 is receive only (state 2) and 11 is full duplex (state 3).
- R6: Source code 2 drives an output pin from the matching bit of `dbg0_bus`, and code 3 from the matching bit of `dbg1_bus`.
- R7: The source codes of receive-side pins 0..15 are at offset 3, and those of transmit-side pins 16..31 are at offset 2. Side pin j uses field bits [2j+1:2j] of its side's register.
- R8: The ATR words sit at offset 4 + 2*state + side (side 0 = receive, 1 = transmit). Each holds 16 bits in data bits [15:0]. A receive word drives pins 0..15 and a transmit word drives pins 16..31 (bit j to side pin j).
- R9: A bus cycle with `set_stb` low, or with an address outside BASE_ADDR .. BASE_ADDR+11, changes no register.
- R10: `pad_rd` shows `pad_in` through two flops. A level applied before a clock edge is not visible after that edge, and is visible after the next one.
- R11: A register write reaches the pins from the clock edge that captures the strobe, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | 8 | Settings word address |
| set_data | input | 32 | Settings write data |
| tx_active | input | 1 | Radio is transmitting |
| rx_active | input | 1 | Radio is receiving |
| dbg0_bus | input | 32 | Debug source 0, one bit per pin |
| dbg1_bus | input | 32 | Debug source 1, one bit per pin |
| pad_in | input | 32 | Pad levels seen from the pins |
| pad_out | output | 32 | Value to drive on each pin |
| pad_oe | output | 32 | Output enable per pin |
| pad_rd | output | 32 | Synchronized pad levels |

## Verification
The bench tries all four source codes against all four radio states, with both full and partial direction masks. Distinct receive and transmit words expose a design that swaps sides, misreads the state bits or indexes the wrong ATR word. A mixed per-pin code pattern, with different patterns on the two sides, catches field offsets that are off by one or select registers that are swapped. Stray writes (strobe low, one address below the range, one address above it) would show up as changed pins if the decoder were loose. Cycle-exact samples around a write and around a pad change catch a missing or extra pipeline stage.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;

   typedef enum logic [1:0] {
      SRC_SW   = 2'd0,
      SRC_ATR  = 2'd1,
      SRC_DBG0 = 2'd2,
      SRC_DBG1 = 2'd3
   } pin_src_e;

   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_TX   = 2'd1,
      RS_RX   = 2'd2,
      RS_FULL = 2'd3
   } radio_state_e;

   localparam int OFS_SW     = 0;
   localparam int OFS_DIR    = 1;
   localparam int OFS_SEL_TX = 2;
   localparam int OFS_SEL_RX = 3;
   localparam int OFS_ATR    = 4;
   localparam int NUM_STATES = 4;
   localparam int NUM_REGS   = OFS_ATR + 2 * NUM_STATES;

   function automatic radio_state_e state_from(input logic tx, input logic rx);
      return radio_state_e'({rx, tx});
   endfunction

endpackage

// File: rtl/gpio_atr_regs.sv
module gpio_atr_regs
   import gpio_atr_pkg::*;
#(
   parameter int SIDE_W    = 16,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int BASE_ADDR = 'h40
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               set_stb,
   input  logic [ADDR_W-1:0]                  set_addr,
   input  logic [DATA_W-1:0]                  set_data,
   output logic [2*SIDE_W-1:0]                sw_q,
   output logic [2*SIDE_W-1:0]                dir_q,
   output logic [2*SIDE_W-1:0]                sel_tx_q,
   output logic [2*SIDE_W-1:0]                sel_rx_q,
   output logic [NUM_STATES-1:0][SIDE_W-1:0]  atr_rx_q,
   output logic [NUM_STATES-1:0][SIDE_W-1:0]  atr_tx_q
);

   localparam int                BANK_W = 2 * SIDE_W;
   localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] END_L  = ADDR_W'(BASE_ADDR + NUM_REGS);

   if (DATA_W != BANK_W) begin : g_bad_width
      $error("gpio_atr_regs: DATA_W must equal 2*SIDE_W");
   end
   if (BASE_ADDR + NUM_REGS > (1 << ADDR_W)) begin : g_bad_base
      $error("gpio_atr_regs: register window exceeds address space");
   end

   logic              hit;
   logic [ADDR_W-1:0] ofs;

   always_comb begin
      ofs = set_addr - BASE_L;
      hit = set_stb && (set_addr >= BASE_L) && (set_addr < END_L);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q     <= '0;
         dir_q    <= '0;
         sel_tx_q <= '0;
         sel_rx_q <= '0;
      end else if (hit) begin
         if (ofs == ADDR_W'(OFS_SW))     sw_q     <= set_data[BANK_W-1:0];
         if (ofs == ADDR_W'(OFS_DIR))    dir_q    <= set_data[BANK_W-1:0];
         if (ofs == ADDR_W'(OFS_SEL_TX)) sel_tx_q <= set_data[BANK_W-1:0];
         if (ofs == ADDR_W'(OFS_SEL_RX)) sel_rx_q <= set_data[BANK_W-1:0];
      end
   end

   for (genvar k = 0; k < 2 * NUM_STATES; k++) begin : g_atr
      logic [SIDE_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (hit && ofs == ADDR_W'(OFS_ATR + k))
            word_q <= set_data[SIDE_W-1:0];
      end
      if (k % 2 == 0) begin : g_rx
         assign atr_rx_q[k/2] = word_q;
      end else begin : g_tx
         assign atr_tx_q[k/2] = word_q;
      end
   end

   // R2: direction write lands one edge later
   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb && set_addr == ADDR_W'(BASE_ADDR + OFS_DIR)) |=> (dir_q == $past(set_data)));

   // R9: stray bus cycles leave the main registers alone
   p_stray_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb || set_addr < BASE_L || set_addr >= END_L)
         |=> ($stable(sw_q) && $stable(dir_q) && $stable(sel_tx_q) && $stable(sel_rx_q)));

endmodule

// File: rtl/gpio_atr_side.sv
module gpio_atr_side
   import gpio_atr_pkg::*;
#(
   parameter int SIDE_W = 16
) (
   input  logic [SIDE_W-1:0]                  sw_val,
   input  logic [SIDE_W-1:0]                  dir,
   input  logic [2*SIDE_W-1:0]                sel,
   input  logic [NUM_STATES-1:0][SIDE_W-1:0]  atr_words,
   input  radio_state_e                       state,
   input  logic [SIDE_W-1:0]                  dbg0,
   input  logic [SIDE_W-1:0]                  dbg1,
   output logic [SIDE_W-1:0]                  drv,
   output logic [SIDE_W-1:0]                  oe
);

   logic [SIDE_W-1:0] atr_now;
   assign atr_now = atr_words[state];

   for (genvar i = 0; i < SIDE_W; i++) begin : g_pin
      pin_src_e src;
      logic     pick;
      assign src = pin_src_e'(sel[2*i +: 2]);
      always_comb begin
         unique case (src)
            SRC_SW:   pick = sw_val[i];
            SRC_ATR:  pick = atr_now[i];
            SRC_DBG0: pick = dbg0[i];
            SRC_DBG1: pick = dbg1[i];
            default:  pick = 1'b0;
         endcase
      end
      assign drv[i] = dir[i] & pick;
      assign oe[i]  = dir[i];
   end

endmodule

// File: rtl/gpio_atr_sync.sv
module gpio_atr_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_atr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= din;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];

   if (STAGES == 2) begin : g_chk2
      logic [1:0] warm;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        warm <= '0;
         else if (warm < 2) warm <= warm + 2'd1;
      end
      // R10: output is the input from two edges back
      p_sync_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (warm == 2'd2) |-> (dout == $past(din, 2)));
   end

endmodule

// File: rtl/gpio_atr_bank.sv
module gpio_atr_bank
   import gpio_atr_pkg::*;
#(
   parameter int SIDE_W      = 16,
   parameter int ADDR_W      = 8,
   parameter int BASE_ADDR   = 'h40,
   parameter int SYNC_STAGES = 2,
   localparam int BANK_W     = 2 * SIDE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_stb,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic [BANK_W-1:0] set_data,
   input  logic              tx_active,
   input  logic              rx_active,
   input  logic [BANK_W-1:0] dbg0_bus,
   input  logic [BANK_W-1:0] dbg1_bus,
   input  logic [BANK_W-1:0] pad_in,
   output logic [BANK_W-1:0] pad_out,
   output logic [BANK_W-1:0] pad_oe,
   output logic [BANK_W-1:0] pad_rd
);

   logic [BANK_W-1:0]                 sw_q, dir_q, sel_tx_q, sel_rx_q;
   logic [NUM_STATES-1:0][SIDE_W-1:0] atr_rx_q, atr_tx_q;
   radio_state_e                      state;

   assign state = state_from(tx_active, rx_active);

   gpio_atr_regs #(
      .SIDE_W(SIDE_W), .ADDR_W(ADDR_W), .DATA_W(BANK_W), .BASE_ADDR(BASE_ADDR)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
      .sw_q(sw_q), .dir_q(dir_q), .sel_tx_q(sel_tx_q), .sel_rx_q(sel_rx_q),
      .atr_rx_q(atr_rx_q), .atr_tx_q(atr_tx_q)
   );

   gpio_atr_side #(.SIDE_W(SIDE_W)) i_rx_side (
      .sw_val(sw_q[SIDE_W-1:0]), .dir(dir_q[SIDE_W-1:0]), .sel(sel_rx_q),
      .atr_words(atr_rx_q), .state(state),
      .dbg0(dbg0_bus[SIDE_W-1:0]), .dbg1(dbg1_bus[SIDE_W-1:0]),
      .drv(pad_out[SIDE_W-1:0]), .oe(pad_oe[SIDE_W-1:0])
   );

   gpio_atr_side #(.SIDE_W(SIDE_W)) i_tx_side (
      .sw_val(sw_q[BANK_W-1:SIDE_W]), .dir(dir_q[BANK_W-1:SIDE_W]), .sel(sel_tx_q),
      .atr_words(atr_tx_q), .state(state),
      .dbg0(dbg0_bus[BANK_W-1:SIDE_W]), .dbg1(dbg1_bus[BANK_W-1:SIDE_W]),
      .drv(pad_out[BANK_W-1:SIDE_W]), .oe(pad_oe[BANK_W-1:SIDE_W])
   );

   gpio_atr_sync #(.WIDTH(BANK_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pad_rd)
   );

   // R3: released pins never carry a driven one
   p_input_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & ~pad_oe) == '0));

   // R2: enables follow the stored direction word
   p_oe_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe == dir_q));

   // R5: receive pin 0 on ATR source tracks the word of the live state
   p_atr_rx0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[0] && sel_rx_q[1:0] == 2'd1) |-> (pad_out[0] == atr_rx_q[{rx_active, tx_active}][0]));

   // R8: transmit pin (SIDE_W) on ATR source uses the transmit-side word
   p_atr_tx0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[SIDE_W] && sel_tx_q[1:0] == 2'd1) |-> (pad_out[SIDE_W] == atr_tx_q[{rx_active, tx_active}][0]));

endmodule

// File: tb/test_gpio_atr_bank.sv
module test_gpio_atr_bank;

   localparam int CLK_PERIOD = 10;
   localparam int BASE = 'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        set_stb = 1'b0;
   logic [7:0]  set_addr = '0;
   logic [31:0] set_data = '0;
   logic        tx_active = 1'b0;
   logic        rx_active = 1'b0;
   logic [31:0] dbg0_bus = 32'hA5F0_0F5A;
   logic [31:0] dbg1_bus = 32'h3C96_C369;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe, pad_rd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_sw = '0, m_dir = '0, m_seltx = '0, m_selrx = '0;
   logic [15:0] m_atr [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_atr_bank i_gpio_atr_bank (
      .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .set_addr(set_addr),
      .set_data(set_data), .tx_active(tx_active), .rx_active(rx_active),
      .dbg0_bus(dbg0_bus), .dbg1_bus(dbg1_bus), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_rd(pad_rd)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] model_out();
      logic [31:0] r;
      for (int p = 0; p < 32; p++) begin
         int side, j, st;
         logic [1:0] code;
         logic b;
         side = (p >= 16) ? 1 : 0;
         j    = p % 16;
         st   = {rx_active, tx_active};
         code = side ? m_seltx[2*j +: 2] : m_selrx[2*j +: 2];
         case (code)
            2'd0: b = m_sw[p];
            2'd1: b = m_atr[2*st + side][j];
            2'd2: b = dbg0_bus[p];
            default: b = dbg1_bus[p];
         endcase
         r[p] = b & m_dir[p];
      end
      return r;
   endfunction

   task automatic wr(input int ofs, input logic [31:0] d);
      @(negedge clk);
      set_stb = 1'b1; set_addr = 8'(BASE + ofs); set_data = d;
      @(negedge clk);
      set_stb = 1'b0;
      case (ofs)
         0: m_sw = d;
         1: m_dir = d;
         2: m_seltx = d;
         3: m_selrx = d;
         default: if (ofs >= 4 && ofs < 12) m_atr[ofs-4] = d[15:0];
      endcase
   endtask

   task automatic set_state(input int st);
      tx_active = st[0];
      rx_active = st[1];
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 8; k++) m_atr[k] = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 oe at reset", pad_oe, '0);
      chk("R1 out at reset", pad_out, '0);
      chk("R1 rd at reset", pad_rd, '0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 oe after release", pad_oe, '0);

      // R2: walking direction bits
      for (int k = 0; k < 32; k += 7) begin
         wr(1, 32'h1 << k); #1;
         chk("R2 direction bit", pad_oe, 32'h1 << k);
      end

      // program value and ATR words
      wr(0, 32'h9C3A_61E5);
      for (int k = 0; k < 8; k++) wr(4 + k, {16'hFFFF, 16'h1357 * 16'(k + 1) ^ 16'h0F0F});

      // sweep source codes, direction masks and states
      for (int code = 0; code < 4; code++) begin
         wr(2, {16{2'(code)}});
         wr(3, {16{2'(code)}});
         for (int dm = 0; dm < 2; dm++) begin
            string tag;
            wr(1, dm ? 32'h3C5A_0FF0 : 32'hFFFF_FFFF);
            if (dm) tag = "R3 partial direction";
            else if (code == 0) tag = "R4 software source";
            else if (code == 1) tag = "R5/R8 ATR source";
            else tag = "R6 debug source";
            for (int st = 0; st < 4; st++) begin
               set_state(st);
               chk(tag, pad_out, model_out());
            end
         end
      end

      // mixed per-pin codes with different side patterns
      wr(1, 32'hFFFF_FFFF);
      wr(3, 32'h1B1B_E4E4);
      wr(2, 32'hD8D8_2727);
      for (int st = 0; st < 4; st++) begin
         set_state(st);
         chk("R7 mixed per-pin codes", pad_out, model_out());
      end

      // R8: ATR only, sides distinct per state
      wr(2, 32'h5555_5555);
      wr(3, 32'h5555_5555);
      for (int st = 0; st < 4; st++) begin
         set_state(st);
         chk("R8 side words", pad_out, {m_atr[2*st+1], m_atr[2*st]});
      end

      // R9: stray cycles
      @(negedge clk);
      set_stb = 1'b0; set_addr = 8'(BASE + 1); set_data = 32'h0;
      @(negedge clk);
      set_stb = 1'b1; set_addr = 8'(BASE + 12); set_data = 32'h0;
      @(negedge clk);
      set_addr = 8'(BASE - 1);
      @(negedge clk);
      set_stb = 1'b0; #1;
      chk("R9 stray oe", pad_oe, 32'hFFFF_FFFF);
      chk("R9 stray out", pad_out, model_out());

      // R11: write visible only after the capturing edge
      @(negedge clk);
      set_stb = 1'b1; set_addr = 8'(BASE + 1); set_data = 32'hA5A5_0F0F;
      #(CLK_PERIOD/4);
      chk("R11 before edge", pad_oe, 32'hFFFF_FFFF);
      @(negedge clk);
      set_stb = 1'b0; m_dir = 32'hA5A5_0F0F; #1;
      chk("R11 after edge", pad_oe, 32'hA5A5_0F0F);
      chk("R11 out after edge", pad_out, model_out());

      // R10: two-flop input path
      for (int n = 0; n < 3; n++) begin
         logic [31:0] prev, v;
         prev = pad_rd;
         v = 32'h8421_F00D ^ (32'h1111_1111 * n);
         @(negedge clk);
         pad_in = v;
         @(negedge clk); #1;
         chk("R10 one edge", pad_rd, prev);
         @(negedge clk); #1;
         chk("R10 two edges", pad_rd, v);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule